// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Resolver

This block answers interrupt-acknowledge reads for an interrupt controller with 64 request sources. Each source has a 3-bit level (1 to 7), a 3-bit priority within its level and a mask bit. A read names one of eight acknowledge registers. One is a software acknowledge that searches every level. The other seven are per-level acknowledges for levels 1 to 7. Each returns a one-byte vector number for the winning source. A ninth selectable register holds the current level, and every level acknowledge loads it.

A handler can issue a software acknowledge near its end. This shows whether another unmasked source is still waiting, so the handler can pass control on without taking a fresh exception. A level acknowledge is the read made while an exception is being taken. When nothing qualifies, the software acknowledge returns 0x00 and a level acknowledge returns the spurious vector 0x18. Source vectors start at 64, so they never match either of these values.

Top module: `iack_vector_resolver`

## Requirements
- R1: After reset `rd_data` is 0x00 and the current-level register is 0. With no requests pending, a software acknowledge returns 0x00 and every level acknowledge returns 0x18.
- R2: A level acknowledge (`rd_sel` 1..7 = level n) considers only sources with `req`=1, `mask`=0 and level n. It returns 64+i for the source i with the largest priority value.
- R3: If two qualifying sources have the same ranking, the source with the lower index wins, for both kinds of acknowledge.
- R4: A software acknowledge (`rd_sel`=0) returns 64+i for the qualifying source with the highest level. Ties on level are broken by the highest priority.
- R5: A software acknowledge with no active unmasked source at levels 1..7 returns 0x00.
- R6: A level acknowledge with no qualifying source at that level returns 0x18.
- R7: A level acknowledge for level n loads n into the current-level register. Reading `rd_sel`=8 returns that register in bits 2:0, with zeros above it.
- R8: A software acknowledge leaves the current-level register unchanged.
- R9: Writes with `wr_sel` 0..7 have no effect. A write with `wr_sel`=8 loads `wr_data` into the current-level register. If a level acknowledge happens in the same cycle, the acknowledge load wins.
- R10: Read data appears on `rd_data` one clock after the `rd_stb` cycle and holds until the next read. Selects 9..15 return 0x00.
- R11: A masked source (`mask`=1), or a source whose level is 0, never wins any acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 64 | Active request per source |
| mask | input | 64 | 1 masks the source |
| src_level | input | 192 | Level of source i in bits [3i+2:3i] |
| src_prio | input | 192 | Priority of source i in bits [3i+2:3i]; a larger value ranks higher |
| rd_stb | input | 1 | Single-cycle read strobe |
| rd_sel | input | 4 | 0 software ack, 1..7 level ack, 8 current level |
| wr_stb | input | 1 | Single-cycle write strobe |
| wr_sel | input | 4 | Write register select |
| wr_data | input | 3 | Write data for the current-level register |
| rd_data | output | 8 | Registered read data |

## Verification
Two actions can update the current-level register in the same cycle: a level acknowledge and a software write with `wr_sel`=8. The bench issues both in one cycle with different values. A later read of select 8 must return the acknowledged level. A software acknowledge paired with a write must leave the written value in place, and a write aimed at an acknowledge register must leave the register unchanged. Random cycles also overlap reads and writes, and a bench reference model checks the results.

// File: rtl/iack_vector_resolver.sv
module iack_vector_resolver #(
  parameter int NSRC     = 64,
  parameter int LVL_W    = 3,
  parameter int PRIO_W   = 3,
  parameter int VEC_BASE = 64,
  parameter logic [7:0] SPUR_VEC = 8'h18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         req,
  input  logic [NSRC-1:0]         mask,
  input  logic [NSRC*LVL_W-1:0]   src_level,
  input  logic [NSRC*PRIO_W-1:0]  src_prio,
  input  logic                    rd_stb,
  input  logic [3:0]              rd_sel,
  input  logic                    wr_stb,
  input  logic [3:0]              wr_sel,
  input  logic [LVL_W-1:0]        wr_data,
  output logic [7:0]              rd_data
);

  localparam int IDX_W = $clog2(NSRC);
  localparam int KEY_W = LVL_W + PRIO_W;
  localparam logic [3:0] SEL_SW  = 4'd0;
  localparam logic [3:0] SEL_CUR = 4'd8;

  logic [LVL_W-1:0] cur_lvl;
  logic             sw_rd, lvl_rd;
  logic             hit;
  logic [KEY_W-1:0] best_key;
  logic [IDX_W-1:0] best_idx;
  logic [LVL_W-1:0] lv;
  logic [PRIO_W-1:0] pr;
  logic [KEY_W-1:0] key;
  logic             ok;
  logic [7:0]       vec, rd_next;

  assign sw_rd  = (rd_sel == SEL_SW);
  assign lvl_rd = !rd_sel[3] && (rd_sel[2:0] != 3'd0);

  always_comb begin
    hit      = 1'b0;
    best_key = '0;
    best_idx = '0;
    lv       = '0;
    pr       = '0;
    key      = '0;
    ok       = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      lv  = src_level[i*LVL_W +: LVL_W];
      pr  = src_prio[i*PRIO_W +: PRIO_W];
      ok  = req[i] && !mask[i] && (lv != '0) && (sw_rd || lv == rd_sel[LVL_W-1:0]);
      key = sw_rd ? {lv, pr} : {{LVL_W{1'b0}}, pr};
      if (ok && (!hit || key > best_key)) begin
        hit      = 1'b1;
        best_key = key;
        best_idx = IDX_W'(i);
      end
    end
  end

  assign vec = 8'(VEC_BASE) + 8'(best_idx);

  always_comb begin
    if (sw_rd)                 rd_next = hit ? vec : 8'h00;
    else if (lvl_rd)           rd_next = hit ? vec : SPUR_VEC;
    else if (rd_sel == SEL_CUR) rd_next = {{(8-LVL_W){1'b0}}, cur_lvl};
    else                       rd_next = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= 8'h00;
      cur_lvl <= '0;
    end else begin
      if (rd_stb) rd_data <= rd_next;
      if (rd_stb && lvl_rd)                    cur_lvl <= rd_sel[LVL_W-1:0];
      else if (wr_stb && wr_sel == SEL_CUR)    cur_lvl <= wr_data;
    end
  end

  a_r2_level_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && lvl_rd |=> (rd_data == SPUR_VEC) || (rd_data >= 8'(VEC_BASE)));

  a_r6_level_empty_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && lvl_rd && !hit |=> rd_data == SPUR_VEC);

  a_r5_sw_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && sw_rd && !hit |=> rd_data == 8'h00);

  a_r7_level_loads_cur: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && lvl_rd |=> cur_lvl == $past(rd_sel[LVL_W-1:0]));

  a_r8_sw_keeps_cur: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && sw_rd && !(wr_stb && wr_sel == SEL_CUR) |=> $stable(cur_lvl));

  a_r9_ack_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && wr_sel != SEL_CUR && !(rd_stb && lvl_rd) |=> $stable(cur_lvl));

  a_r10_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

endmodule

// File: tb/iack_vector_resolver_bench.sv
module iack_vector_resolver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0, mask = '0;
  logic [N*3-1:0] src_level = '0, src_prio = '0;
  logic         rd_stb = 1'b0, wr_stb = 1'b0;
  logic [3:0]   rd_sel = '0, wr_sel = '0;
  logic [2:0]   wr_data = '0;
  logic [7:0]   rd_data;

  int checks = 0, errors = 0;
  logic [2:0] exp_lvl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iack_vector_resolver u_iack_vector_resolver (
    .clk(clk), .rst_n(rst_n), .req(req), .mask(mask),
    .src_level(src_level), .src_prio(src_prio),
    .rd_stb(rd_stb), .rd_sel(rd_sel), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_data(rd_data));

  function automatic logic [7:0] model(input logic [3:0] sel, input logic [2:0] lvl_now);
    bit hit = 0;
    int bk = 0, bi = 0;
    for (int i = 0; i < N; i++) begin
      int l = int'(src_level[3*i +: 3]);
      int p = int'(src_prio[3*i +: 3]);
      int k = (sel == 0) ? l * 8 + p : p;
      if (req[i] && !mask[i] && l != 0 && (sel == 0 || l == int'(sel)) && (!hit || k > bk)) begin
        hit = 1; bk = k; bi = i;
      end
    end
    if (sel == 0) return hit ? 8'(64 + bi) : 8'h00;
    if (sel < 8)  return hit ? 8'(64 + bi) : 8'h18;
    if (sel == 8) return {5'b0, lvl_now};
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [3:0] rs, input bit dow, input logic [3:0] ws,
                        input logic [2:0] wd, input string tag);
    logic [7:0] e;
    @(negedge clk);
    e = model(rs, exp_lvl);
    rd_stb = 1'b1; rd_sel = rs;
    wr_stb = dow; wr_sel = ws; wr_data = wd;
    if (rs >= 1 && rs <= 7) exp_lvl = rs[2:0];
    else if (dow && ws == 8) exp_lvl = wd;
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0;
    check(tag, rd_data, e);
  endtask

  task automatic set_src(input int i, input bit r, input bit m, input int l, input int p);
    req[i] = r; mask[i] = m;
    src_level[3*i +: 3] = 3'(l);
    src_prio[3*i +: 3] = 3'(p);
  endtask

  task automatic randomize_sources(input int density);
    for (int i = 0; i < N; i++) begin
      req[i]  = ($urandom % 100) < density;
      mask[i] = ($urandom % 4) == 0;
      src_level[3*i +: 3] = 3'($urandom);
      src_prio[3*i +: 3]  = 3'($urandom);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset rd_data", rd_data, 8'h00);
    access(4'd8, 0, 4'd0, 3'd0, "R1 reset current level");
    access(4'd0, 0, 4'd0, 3'd0, "R1 R5 empty software ack");
    for (int n = 1; n <= 7; n++) access(4'(n), 0, 4'd0, 3'd0, "R1 R6 empty level ack");
    access(4'd8, 0, 4'd0, 3'd0, "R7 current level after level 7 ack");

    for (int i = 0; i < N; i++) set_src(i, 0, 0, 5, 4);
    set_src(10, 1, 0, 5, 4); set_src(40, 1, 0, 5, 4);
    access(4'd5, 0, 4'd0, 3'd0, "R3 tie level ack");
    access(4'd0, 0, 4'd0, 3'd0, "R3 tie software ack");
    set_src(50, 1, 0, 5, 6);
    access(4'd5, 0, 4'd0, 3'd0, "R2 higher priority wins");
    set_src(3, 1, 0, 6, 0);
    access(4'd0, 0, 4'd0, 3'd0, "R4 higher level beats priority");
    access(4'd6, 0, 4'd0, 3'd0, "R2 level 6 only source");
    access(4'd4, 0, 4'd0, 3'd0, "R6 empty level 4");
    set_src(3, 1, 1, 7, 7); set_src(7, 1, 0, 0, 7);
    access(4'd0, 0, 4'd0, 3'd0, "R11 masked and level 0 excluded");
    access(4'd7, 0, 4'd0, 3'd0, "R11 masked level 7 gives spurious");
    req = '0;
    set_src(7, 1, 0, 0, 7);
    access(4'd0, 0, 4'd0, 3'd0, "R11 R5 level 0 only gives zero");

    access(4'd3, 1, 4'd8, 3'd6, "R9 ack and write same cycle");
    access(4'd8, 0, 4'd0, 3'd0, "R9 ack load wins");
    access(4'd0, 1, 4'd8, 3'd2, "R8 software ack with write");
    access(4'd8, 0, 4'd0, 3'd0, "R8 write kept over software ack");
    access(4'd0, 0, 4'd0, 3'd0, "R8 software ack alone");
    access(4'd8, 0, 4'd0, 3'd0, "R8 level unchanged");
    access(4'd12, 1, 4'd2, 3'd5, "R10 unused select reads zero");
    access(4'd8, 1, 4'd0, 3'd1, "R9 write to ack register ignored");

    set_src(20, 1, 0, 2, 3);
    access(4'd2, 0, 4'd0, 3'd0, "R2 level 2 vector");
    req = '0;
    repeat (3) @(negedge clk);
    check("R10 data held without read", rd_data, 8'd84);

    for (int t = 0; t < 600; t++) begin
      logic [3:0] s;
      randomize_sources((t % 3 == 0) ? 4 : 30);
      s = 4'($urandom % 10);
      access(s, ($urandom % 2) == 1, 4'($urandom % 10), 3'($urandom),
             "R2 R4 R9 random access");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule